// File: doc/BRIEF.md
# Shift-Register Hardware Call Stack

This block is a fixed-depth hardware stack used for subroutine call/return and explicit save/restore. Each slot holds a full 32-bit word together with a carry flag and a zero flag. There is no pointer and no fill counter: the slots form a shift chain. A push loads the new word and flags into the top slot and moves every other slot one place deeper. A pop shifts every slot one place toward the top.

The block has no empty or full state. When the chain already holds as many values as it has slots, a push pushes the deepest value out of the chain and it is lost. A pop leaves the deepest slot as it was, so that value is copied into the slot above it. When more values are popped than were pushed, the stack returns the deepest value again and again and does not return zero. The top word and its flags come straight from the top slot register, so a consumer sees them with no added delay.

When push and pop are requested in the same cycle, the top slot is overwritten with the incoming value and no other slot changes.

Top module: `hw_call_stack`

## Requirements
- R1: After reset every slot holds data 0 with both flags 0, so the top outputs read data 0, carry 0 and zero 0.
- R2: The stack has DEPTH slots (default 8). Each slot stores DATA_W bits of data (default 32) plus one carry bit and one zero bit. A full-width value such as 0xFFFFFFFF comes back unchanged after a push and a later pop.
- R3: A push with no pop loads push data, carry and zero into the top slot, and in the same cycle each slot k takes the old contents of slot k-1.
- R4: When a push occurs with all slots holding pushed values, the deepest value is discarded. The older values that remain come back in last-in-first-out order.
- R5: A pop with no push moves each slot k-1 to the contents of slot k. The deepest slot keeps its own contents.
- R6: After more pops than pushes, each further pop shows the deepest value on the top outputs. It never shows zero unless zero is the value that was pushed.
- R7: When push and pop occur together, the top slot takes the push data and flags and every deeper slot stays unchanged.
- R8: The top outputs reflect the top slot register directly. A push or pop issued at a clock edge is visible on the outputs after that edge, with no further delay.
- R9: When neither push nor pop is asserted, the contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push request |
| push_data | input | 32 | Word to push |
| push_c | input | 1 | Carry flag to push |
| push_z | input | 1 | Zero flag to push |
| pop_en | input | 1 | Pop request |
| top_data | output | 32 | Word in the top slot |
| top_c | output | 1 | Carry flag in the top slot |
| top_z | output | 1 | Zero flag in the top slot |

## Verification
Several input patterns are driven into the stack:
- Pushes of distinct walking-bit and all-ones words with varied flags show whether every data bit and each flag stays in its own slot.
- Pushing ten values and then popping them shows whether the deepest value is discarded correctly and whether the last-in-first-out order is kept.
- Popping well past the number of pushes shows whether the deepest value is copied upward or whether zero appears.
- Simultaneous push and pop, mixed with idle cycles, tells the top-replace case apart from a real shift.

A queue-based model predicts the top outputs, and they are compared with it after every edge.

// File: rtl/hw_call_stack_pkg.sv
package hw_call_stack_pkg;
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              c;
        logic              z;
    } stk_entry_t;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'b00,
        OP_PUSH    = 2'b01,
        OP_POP     = 2'b10,
        OP_REPLACE = 2'b11
    } stk_op_t;
endpackage

// File: rtl/hw_call_stack_ctrl.sv
module hw_call_stack_ctrl
    import hw_call_stack_pkg::*;
(
    input  logic    push_en,
    input  logic    pop_en,
    output stk_op_t op
);
    always_comb begin
        unique case ({pop_en, push_en})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_REPLACE;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/hw_call_stack_slot.sv
module hw_call_stack_slot
    import hw_call_stack_pkg::*;
#(
    parameter bit IS_TOP    = 1'b0,
    parameter bit IS_BOTTOM = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  stk_op_t    op,
    input  stk_entry_t fresh,
    input  stk_entry_t from_above,
    input  stk_entry_t from_below,
    output stk_entry_t slot_q
);
    stk_entry_t slot_d;

    always_comb begin
        slot_d = slot_q;
        unique case (op)
            OP_PUSH: begin
                if (IS_TOP) slot_d = fresh;
                else        slot_d = from_above;
            end
            OP_POP: begin
                if (!IS_BOTTOM) slot_d = from_below;
            end
            OP_REPLACE: begin
                if (IS_TOP) slot_d = fresh;
            end
            default: slot_d = slot_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/hw_call_stack.sv
module hw_call_stack
    import hw_call_stack_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_c,
    input  logic              push_z,
    input  logic              pop_en,
    output logic [DATA_W-1:0] top_data,
    output logic              top_c,
    output logic              top_z
);
    localparam int unsigned LAST = DEPTH - 1;

    stk_op_t    op;
    stk_entry_t fresh;
    stk_entry_t slots [DEPTH];

    assign fresh = '{data: push_data, c: push_c, z: push_z};

    hw_call_stack_ctrl u_ctrl (
        .push_en (push_en),
        .pop_en  (pop_en),
        .op      (op)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        stk_entry_t above_w, below_w;
        if (k == 0) begin : g_top
            assign above_w = fresh;
        end else begin : g_mid_a
            assign above_w = slots[k-1];
        end
        if (k == LAST) begin : g_bot
            assign below_w = slots[k];
        end else begin : g_mid_b
            assign below_w = slots[k+1];
        end
        hw_call_stack_slot #(
            .IS_TOP    (k == 0),
            .IS_BOTTOM (k == LAST)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .op         (op),
            .fresh      (fresh),
            .from_above (above_w),
            .from_below (below_w),
            .slot_q     (slots[k])
        );
    end

    assign top_data = slots[0].data;
    assign top_c    = slots[0].c;
    assign top_z    = slots[0].z;
endmodule

// File: rtl/hw_call_stack_chk.sv
module hw_call_stack_chk
    import hw_call_stack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              push_en,
    input logic [DATA_W-1:0] push_data,
    input logic              push_c,
    input logic              push_z,
    input logic              pop_en,
    input logic [DATA_W-1:0] top_data,
    input logic              top_c,
    input logic              top_z
);
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    // R3 / R7: any push lands on top
    p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        push_en |=> (top_data == $past(push_data) && top_c == $past(push_c) && top_z == $past(push_z)));

    // R9: idle keeps the top steady
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!push_en && !pop_en) |=> ($stable(top_data) && $stable(top_c) && $stable(top_z)));

    // R1: reset clears the top
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (top_data == '0 && !top_c && !top_z));

    // R7: replace with the same value keeps the top unchanged
    p_replace_same_r7: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (push_en && pop_en && push_data == top_data && push_c == top_c && push_z == top_z)
        |=> $stable(top_data));
endmodule

bind hw_call_stack hw_call_stack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_data (push_data),
    .push_c    (push_c),
    .push_z    (push_z),
    .pop_en    (pop_en),
    .top_data  (top_data),
    .top_c     (top_c),
    .top_z     (top_z)
);

// File: tb/sim_hw_call_stack.sv
module sim_hw_call_stack;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_en = 1'b0, pop_en = 1'b0, push_c = 1'b0, push_z = 1'b0;
    logic [31:0] push_data = '0;
    logic [31:0] top_data;
    logic        top_c, top_z;

    int errors = 0;
    int checks = 0;
    logic [33:0] model [DEPTH];

    always #2.5 clk = ~clk;

    hw_call_stack #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
        .push_c(push_c), .push_z(push_z), .pop_en(pop_en),
        .top_data(top_data), .top_c(top_c), .top_z(top_z)
    );

    task automatic check_top(string req);
        checks++;
        if ({top_data, top_c, top_z} !== model[0]) begin
            errors++;
            $display("FAIL %s: got %h c%b z%b expected %h c%b z%b", req,
                     top_data, top_c, top_z, model[0][33:2], model[0][1], model[0][0]);
        end
    endtask

    task automatic check_val(string req, logic [33:0] exp);
        checks++;
        if ({top_data, top_c, top_z} !== exp) begin
            errors++;
            $display("FAIL %s: got %h_%b%b expected %h_%b%b", req,
                     top_data, top_c, top_z, exp[33:2], exp[1], exp[0]);
        end
    endtask

    // model update: queue-like behavioural reference
    task automatic step(input logic pu, input logic po, input logic [31:0] d,
                        input logic c, input logic z, string req);
        logic [33:0] nxt [DEPTH];
        push_en = pu; pop_en = po; push_data = d; push_c = c; push_z = z;
        for (int i = 0; i < DEPTH; i++) nxt[i] = model[i];
        if (pu && po) nxt[0] = {d, c, z};
        else if (pu) begin
            for (int i = DEPTH-1; i > 0; i--) nxt[i] = model[i-1];
            nxt[0] = {d, c, z};
        end else if (po) begin
            for (int i = 0; i < DEPTH-1; i++) nxt[i] = model[i+1];
        end
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model[i] = nxt[i];
        #1;
        push_en = 1'b0; pop_en = 1'b0;
        check_top(req);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check_top("R1 reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_top("R1 after release");

        // R2 / R3: walking bits, varied flags
        step(1, 0, 32'hFFFF_FFFF, 1, 1, "R2 full width push");
        step(1, 0, 32'h8000_0001, 0, 1, "R3 push");
        step(1, 0, 32'h0001_0000, 1, 0, "R3 push");
        step(0, 0, 32'hDEAD_BEEF, 1, 1, "R9 idle");
        step(0, 1, 0, 0, 0, "R5 pop");
        step(0, 1, 0, 0, 0, "R5 pop");
        check_val("R2 round trip", {32'hFFFF_FFFF, 2'b11});

        // R4: overflow with ten pushes
        for (int i = 0; i < 10; i++)
            step(1, 0, 32'hA000_0000 + i, i[0], i[1], "R4 push");
        for (int i = 0; i < DEPTH; i++)
            step(0, 1, 0, 0, 0, "R4 pop order");
        // R6: deepest value (pushed index 2) replicates
        check_val("R6 bottom replicate", {32'hA000_0002, 1'b0, 1'b1});
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0, 0, "R6 over-pop");
            check_val("R6 no zero", {32'hA000_0002, 1'b0, 1'b1});
        end

        // R7: simultaneous push and pop
        step(1, 0, 32'h1111_1111, 1, 0, "R3 push");
        step(1, 1, 32'h2222_2222, 0, 1, "R7 replace");
        step(0, 1, 0, 0, 0, "R7 deeper unchanged");
        check_val("R7 deeper unchanged", {32'hA000_0002, 1'b0, 1'b1});
        step(0, 0, 32'h5555_5555, 1, 1, "R9 idle");
        step(1, 0, 32'h0000_0000, 0, 0, "R8 immediate");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule